// File: doc/BRIEF.md
# Status Word Move Unit

This block keeps two 32-bit status words, a live one and a banked copy, and carries out the two moves between them and the general register file. A status-to-register move returns one of the two words, tagged with the destination register index. A register-to-status move merges a new operand into one of the two words. It replaces only the bytes that a 4-bit lane selector enables, and leaves the other bytes as they were.

The operand of a merge comes from one of two places. The first is the general register named by the low nibble of the instruction word, which the register file supplies through `opnd_reg` after looking up `opnd_idx`. The second is an 8-bit constant inside the instruction word, rotated right by an even amount. Merges into the live word are dropped unless the caller is privileged. Merges into the banked copy are always carried out, and if the current mode has no banked copy the unit raises a one-cycle fault pulse. Mode changes and exception entry are left to the surrounding core.

Top module: `stat_move_unit`

## Requirements
- R1: A synchronous active-high reset clears both status words to zero and drives `rd_valid` and `bank_fault` low in the following cycle.
- R2: On a merge, lane i of the selector enables byte i of the target word (bits 8i+7 down to 8i). The new word is (old AND NOT lanes) OR (operand AND lanes), and it is visible on the status output one clock after the request.
- R3: The lane selector is bits 19:16 of `instr`. Bit 16 controls byte 0 and bit 19 controls byte 3. A selector of zero leaves the target word unchanged.
- R4: When `req_imm` is high, the operand is `instr[7:0]` zero-extended and rotated right by twice the value of `instr[11:8]`, so the rotation is always even and ranges from 0 to 30.
- R5: When `req_imm` is low, the operand is `opnd_reg`. The unit presents `instr[3:0]` on `opnd_idx` combinationally so that the register file can return that register.
- R6: A merge into the live word (`req_bank` low) takes effect only while `priv` is high. Otherwise the live word keeps its value.
- R7: A merge into the banked copy (`req_bank` high) takes effect whatever the values of `priv` and `has_bank`.
- R8: A read (`req_wr` low) raises `rd_valid` for one cycle after the request. In that cycle `rd_data` holds the banked copy if `req_bank` was high and the live word otherwise, and `rd_index` equals `instr[15:12]`.
- R9: `bank_fault` is high for exactly the cycle after a valid request with `req_bank` high that arrives while `has_bank` is low. Any other request, or no request, leaves it low.
- R10: While `req_valid` is low, neither status word changes and `rd_valid` stays low, whatever the other request inputs carry.
- R11: A merge changes only its target word. The other status word keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe |
| req_wr | input | 1 | 1 = merge into a status word, 0 = read a status word |
| req_bank | input | 1 | 1 = banked copy, 0 = live word |
| req_imm | input | 1 | 1 = rotated constant operand, 0 = register operand |
| instr | input | 32 | Instruction word carrying the lane selector, destination, rotation and operand fields |
| opnd_reg | input | 32 | Value of the general register named by `opnd_idx` |
| priv | input | 1 | High when the current mode is privileged |
| has_bank | input | 1 | High when the current mode owns a banked copy |
| opnd_idx | output | 4 | Operand register index, `instr[3:0]` |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 32 | Read result |
| rd_index | output | 4 | Destination register index of the read |
| live_word | output | 32 | Current live status word |
| bank_word | output | 32 | Current banked status copy |
| bank_fault | output | 1 | One-cycle pulse for a banked access in a mode without a banked copy |

## Verification
A merge into the banked copy while `has_bank` is low causes two things on the same clock edge: the word is updated and the fault pulse fires. A read of the banked copy in such a mode causes only the fault. The random stream draws `has_bank` low often and mixes banked reads and merges, and directed cases force both situations. Each cycle is judged by comparing the merged word and the fault bit together against the model, so a design that drops the update while raising the fault, or the reverse, is caught.

// File: rtl/stat_move_pkg.sv
package stat_move_pkg;

   // Instruction word field positions (the block decodes these)
   localparam int INSTR_W   = 32;
   localparam int SEL_LSB   = 16;   // lane selector, 4 bits
   localparam int DST_LSB   = 12;   // read destination index, 4 bits
   localparam int ROT_LSB   = 8;    // immediate rotation, 4 bits
   localparam int CONST_LSB = 0;    // immediate constant, 8 bits
   localparam int SRC_LSB   = 0;    // operand register index, 4 bits
   localparam int IDX_W     = 4;

   // Rotator variants
   localparam int ROT_STAGED = 0;
   localparam int ROT_WIDE   = 1;

   typedef struct packed {
      logic valid;
      logic wr;
      logic bank;
      logic imm;
   } move_req_t;

endpackage

// File: rtl/stat_operand_gen.sv
module stat_operand_gen
   import stat_move_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int CONST_W   = 8,
   parameter int ROT_W     = 4,
   parameter int ROT_STYLE = ROT_STAGED
) (
   input  logic [CONST_W-1:0] const_val,
   input  logic [ROT_W-1:0]   rot_val,
   input  logic [DATA_W-1:0]  reg_val,
   input  logic               use_const,
   output logic [DATA_W-1:0]  operand
);

   localparam int AMT_W = $clog2(DATA_W);

   initial begin
      assert (CONST_W <= DATA_W)
         else $fatal(1, "stat_operand_gen: constant wider than data");
      assert (ROT_W + 1 <= AMT_W)
         else $fatal(1, "stat_operand_gen: rotation field too wide");
      assert ((1 << AMT_W) == DATA_W)
         else $fatal(1, "stat_operand_gen: data width must be a power of two");
      assert (ROT_STYLE == ROT_STAGED || ROT_STYLE == ROT_WIDE)
         else $fatal(1, "stat_operand_gen: unknown rotator style");
   end

   logic [DATA_W-1:0] base;
   logic [AMT_W-1:0]  amt;
   logic [DATA_W-1:0] rotated;

   always_comb begin
      base = '0;
      base[CONST_W-1:0] = const_val;
      amt = '0;
      amt[ROT_W:1] = rot_val;
   end

   generate
      if (ROT_STYLE == ROT_STAGED) begin : g_staged
         logic [AMT_W:0][DATA_W-1:0] stage;
         assign stage[0] = base;
         for (genvar k = 0; k < AMT_W; k++) begin : g_step
            localparam int SH = 1 << k;
            assign stage[k+1] = amt[k]
               ? {stage[k][SH-1:0], stage[k][DATA_W-1:SH]}
               : stage[k];
         end
         assign rotated = stage[AMT_W];
      end else begin : g_wide
         logic [2*DATA_W-1:0] doubled;
         logic [2*DATA_W-1:0] shifted;
         always_comb begin
            doubled = {base, base};
            shifted = doubled >> amt;
         end
         assign rotated = shifted[DATA_W-1:0];
      end
   endgenerate

   assign operand = use_const ? rotated : reg_val;

endmodule

// File: rtl/stat_lane_mask.sv
module stat_lane_mask #(
   parameter int DATA_W = 32,
   parameter int LANES  = 4
) (
   input  logic [LANES-1:0]  sel,
   output logic [DATA_W-1:0] mask
);

   localparam int LANE_W = DATA_W / LANES;

   initial begin
      assert (LANES > 0 && LANE_W * LANES == DATA_W)
         else $fatal(1, "stat_lane_mask: data width not divisible into lanes");
   end

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         assign mask[i*LANE_W +: LANE_W] = {LANE_W{sel[i]}};
      end
   endgenerate

endmodule

// File: rtl/stat_word_slot.sv
module stat_word_slot #(
   parameter int          DATA_W    = 32,
   parameter logic [31:0] RESET_VAL = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              merge_en,
   input  logic [DATA_W-1:0] lane_mask,
   input  logic [DATA_W-1:0] operand,
   output logic [DATA_W-1:0] word
);

   logic [DATA_W-1:0] merged;

   always_comb begin
      merged = (word & ~lane_mask) | (operand & lane_mask);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         word <= RESET_VAL[DATA_W-1:0];
      end else if (merge_en) begin
         word <= merged;
      end
   end

endmodule

// File: rtl/stat_move_unit.sv
module stat_move_unit
   import stat_move_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int LANES     = 4,
   parameter int CONST_W   = 8,
   parameter int ROT_W     = 4,
   parameter int ROT_STYLE = ROT_STAGED
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic              req_wr,
   input  logic              req_bank,
   input  logic              req_imm,
   input  logic [31:0]       instr,
   input  logic [DATA_W-1:0] opnd_reg,
   input  logic              priv,
   input  logic              has_bank,
   output logic [3:0]        opnd_idx,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [3:0]        rd_index,
   output logic [DATA_W-1:0] live_word,
   output logic [DATA_W-1:0] bank_word,
   output logic              bank_fault
);

   initial begin
      assert (LANES == 4)
         else $fatal(1, "stat_move_unit: lane selector field is 4 bits");
      assert (CONST_W == 8 && ROT_W == 4)
         else $fatal(1, "stat_move_unit: immediate fields are fixed in the instruction");
   end

   move_req_t req;
   always_comb begin
      req.valid = req_valid;
      req.wr    = req_wr;
      req.bank  = req_bank;
      req.imm   = req_imm;
   end

   logic [LANES-1:0]  lane_sel;
   logic [DATA_W-1:0] lane_mask;
   logic [DATA_W-1:0] operand;
   logic              merge_live;
   logic              merge_bank;
   logic              is_read;
   logic              fault_now;

   assign lane_sel = instr[SEL_LSB +: LANES];
   assign opnd_idx = instr[SRC_LSB +: IDX_W];

   always_comb begin
      merge_live = req.valid & req.wr & ~req.bank & priv;
      merge_bank = req.valid & req.wr & req.bank;
      is_read    = req.valid & ~req.wr;
      fault_now  = req.valid & req.bank & ~has_bank;
   end

   stat_operand_gen #(
      .DATA_W    (DATA_W),
      .CONST_W   (CONST_W),
      .ROT_W     (ROT_W),
      .ROT_STYLE (ROT_STYLE)
   ) u_operand (
      .const_val (instr[CONST_LSB +: CONST_W]),
      .rot_val   (instr[ROT_LSB +: ROT_W]),
      .reg_val   (opnd_reg),
      .use_const (req.imm),
      .operand   (operand)
   );

   stat_lane_mask #(
      .DATA_W (DATA_W),
      .LANES  (LANES)
   ) u_mask (
      .sel  (lane_sel),
      .mask (lane_mask)
   );

   stat_word_slot #(.DATA_W(DATA_W)) u_live (
      .clk       (clk),
      .rst       (rst),
      .merge_en  (merge_live),
      .lane_mask (lane_mask),
      .operand   (operand),
      .word      (live_word)
   );

   stat_word_slot #(.DATA_W(DATA_W)) u_bank (
      .clk       (clk),
      .rst       (rst),
      .merge_en  (merge_bank),
      .lane_mask (lane_mask),
      .operand   (operand),
      .word      (bank_word)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_valid   <= 1'b0;
         rd_data    <= '0;
         rd_index   <= '0;
         bank_fault <= 1'b0;
      end else begin
         rd_valid   <= is_read;
         bank_fault <= fault_now;
         if (is_read) begin
            rd_data  <= req.bank ? bank_word : live_word;
            rd_index <= instr[DST_LSB +: IDX_W];
         end
      end
   end

endmodule

// File: rtl/stat_move_unit_chk.sv
module stat_move_unit_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst,
   input logic              req_valid,
   input logic              req_wr,
   input logic              req_bank,
   input logic [31:0]       instr,
   input logic              priv,
   input logic              has_bank,
   input logic [3:0]        opnd_idx,
   input logic              rd_valid,
   input logic [DATA_W-1:0] rd_data,
   input logic [3:0]        rd_index,
   input logic [DATA_W-1:0] live_word,
   input logic [DATA_W-1:0] bank_word,
   input logic              bank_fault
);

   // R5: the operand index follows the instruction low nibble
   always_comb begin
      a_r5_opnd_idx: assert (opnd_idx == instr[3:0]);
   end

   a_r6_unpriv_live_held: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_wr && !req_bank && !priv) |=> $stable(live_word));

   a_r11_live_merge_spares_bank: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_wr && !req_bank) |=> $stable(bank_word));

   a_r11_bank_merge_spares_live: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_wr && req_bank) |=> $stable(live_word));

   a_r3_empty_selector: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_wr && instr[19:16] == 4'b0000)
      |=> ($stable(live_word) && $stable(bank_word)));

   a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
      !req_valid |=> ($stable(live_word) && $stable(bank_word) && !rd_valid));

   a_r8_read_valid: assert property (@(posedge clk) disable iff (rst)
      (req_valid && !req_wr) |=> (rd_valid && rd_index == $past(instr[15:12])));

   a_r8_read_bank: assert property (@(posedge clk) disable iff (rst)
      (req_valid && !req_wr && req_bank) |=> (rd_data == $past(bank_word)));

   a_r8_read_live: assert property (@(posedge clk) disable iff (rst)
      (req_valid && !req_wr && !req_bank) |=> (rd_data == $past(live_word)));

   a_r9_fault_raised: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_bank && !has_bank) |=> bank_fault);

   a_r9_fault_quiet: assert property (@(posedge clk) disable iff (rst)
      !(req_valid && req_bank && !has_bank) |=> !bank_fault);

endmodule

bind stat_move_unit stat_move_unit_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .req_valid  (req_valid),
   .req_wr     (req_wr),
   .req_bank   (req_bank),
   .instr      (instr),
   .priv       (priv),
   .has_bank   (has_bank),
   .opnd_idx   (opnd_idx),
   .rd_valid   (rd_valid),
   .rd_data    (rd_data),
   .rd_index   (rd_index),
   .live_word  (live_word),
   .bank_word  (bank_word),
   .bank_fault (bank_fault)
);

// File: tb/test_stat_move_unit.sv
module test_stat_move_unit;

   logic        clk = 1'b0;
   logic        rst;
   logic        req_valid, req_wr, req_bank, req_imm;
   logic [31:0] instr, opnd_reg;
   logic        priv, has_bank;
   logic [3:0]  opnd_idx;
   logic        rd_valid;
   logic [31:0] rd_data;
   logic [3:0]  rd_index;
   logic [31:0] live_word, bank_word;
   logic        bank_fault;

   int checks = 0;
   int fails  = 0;
   logic [31:0] m_live, m_bank;

   always #2 clk = ~clk;   // 250 MHz

   stat_move_unit i_stat_move_unit (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_wr(req_wr),
      .req_bank(req_bank), .req_imm(req_imm), .instr(instr),
      .opnd_reg(opnd_reg), .priv(priv), .has_bank(has_bank),
      .opnd_idx(opnd_idx), .rd_valid(rd_valid), .rd_data(rd_data),
      .rd_index(rd_index), .live_word(live_word), .bank_word(bank_word),
      .bank_fault(bank_fault)
   );

   function automatic logic [31:0] rot_right(logic [31:0] x, int n);
      logic [31:0] r = x;
      for (int i = 0; i < n; i++) r = {r[0], r[31:1]};
      return r;
   endfunction

   function automatic logic [31:0] lanes(logic [3:0] s);
      logic [31:0] m = '0;
      for (int i = 0; i < 4; i++) if (s[i]) m[8*i +: 8] = 8'hFF;
      return m;
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   // Drive one request at the falling edge, judge after the next rising edge.
   task automatic step(logic v, logic w, logic b, logic im, logic [31:0] ins,
                       logic [31:0] rop, logic p, logic hb);
      logic [31:0] opnd, msk, exp_rd;
      @(negedge clk);
      req_valid = v; req_wr = w; req_bank = b; req_imm = im;
      instr = ins; opnd_reg = rop; priv = p; has_bank = hb;
      #0.5;
      check("R5 opnd_idx", {28'd0, opnd_idx}, {28'd0, ins[3:0]});
      opnd   = im ? rot_right({24'd0, ins[7:0]}, 2 * ins[11:8]) : rop;
      msk    = lanes(ins[19:16]);
      exp_rd = b ? m_bank : m_live;
      if (v && w && b)            m_bank = (m_bank & ~msk) | (opnd & msk);
      if (v && w && !b && p)      m_live = (m_live & ~msk) | (opnd & msk);
      @(negedge clk);
      check("R2/R4/R6/R10 live_word", live_word, m_live);
      check("R2/R7/R11 bank_word", bank_word, m_bank);
      check("R8/R10 rd_valid", {31'd0, rd_valid}, {31'd0, v && !w});
      if (v && !w) begin
         check("R8 rd_data", rd_data, exp_rd);
         check("R8 rd_index", {28'd0, rd_index}, {28'd0, ins[15:12]});
      end
      check("R9 bank_fault", {31'd0, bank_fault}, {31'd0, v && b && !hb});
   endtask

   function automatic logic [31:0] mk(logic [3:0] sel, logic [3:0] dst,
                                      logic [3:0] rot, logic [7:0] c);
      return {12'd0, sel, dst, rot, c};
   endfunction

   initial begin
      #150000;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      rst = 1'b1; req_valid = 0; req_wr = 0; req_bank = 0; req_imm = 0;
      instr = '0; opnd_reg = '0; priv = 0; has_bank = 0;
      m_live = '0; m_bank = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 live_word", live_word, 32'h0);
      check("R1 bank_word", bank_word, 32'h0);
      check("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
      check("R1 bank_fault", {31'd0, bank_fault}, 32'd0);
      rst = 1'b0;

      // R2 R3 all lanes, register form (R5)
      step(1,1,0,0, mk(4'hF,0,0,8'h03), 32'hDEADBEEF, 1, 1);
      // R3 empty selector
      step(1,1,0,0, mk(4'h0,0,0,8'h03), 32'h12345678, 1, 1);
      // R3 single lane bit 16 -> byte 0 only
      step(1,1,0,0, mk(4'h1,0,0,8'h00), 32'h11223344, 1, 1);
      // R3 bit 19 -> byte 3 only
      step(1,1,0,0, mk(4'h8,0,0,8'h00), 32'hAA000000, 1, 1);
      // R4 rotation zero and max (30)
      step(1,1,0,1, mk(4'hF,0,4'h0,8'hAB), 32'hFFFFFFFF, 1, 1);
      step(1,1,0,1, mk(4'hF,0,4'hF,8'hAB), 32'h0, 1, 1);
      step(1,1,1,1, mk(4'h5,0,4'h4,8'hC3), 32'h0, 1, 1);
      // R6 unprivileged live merge dropped
      step(1,1,0,0, mk(4'hF,0,0,0), 32'h55555555, 0, 1);
      // R7 R9 banked merge with no banked copy: update and fault together
      step(1,1,1,0, mk(4'hF,0,0,0), 32'h0BADF00D, 0, 0);
      // R8 reads, R9 read fault
      step(1,0,1,0, mk(4'h0,4'h7,0,0), 32'h0, 0, 0);
      step(1,0,0,0, mk(4'h0,4'hE,0,0), 32'h0, 1, 1);
      // R10 idle with write fields set
      step(0,1,1,1, mk(4'hF,0,4'h3,8'hFF), 32'hFFFFFFFF, 1, 0);

      for (int n = 0; n < 4000; n++) begin
         logic [31:0] r1, r2;
         r1 = $urandom; r2 = $urandom;
         step(r1[0] | r1[1], r1[2], r1[3], r1[4], r2, $urandom,
              r1[5] | r1[6], r1[7]);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule